// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable pipelined synchronous SRAM that never needs an idle cycle between a read and a write. Each rising clock edge accepts one operation: a fresh read or write with an external address, a burst continue, or a deselect. The data that belongs to an operation moves two clock edges after the operation itself, and this is true for writes as well as reads. A read can therefore follow a write, or a write follow a read, on every cycle with the data bus fully used.

A built-in two-bit burst counter produces four word addresses from one external address, in linear or interleaved order. A burst continue keeps the direction of the operation that started the burst. Three chip selects allow depth expansion. Per-lane write enables mask the bytes of a word. An active-low clock enable freezes every register in the block. The bidirectional data bus is modelled as separate input, output and output-enable signals. An asynchronous output enable can turn off the output drivers at any moment.

Top module: `zbt_sram`

## Requirements
- R1: All synchronous inputs are sampled on the rising edge of `clk`. For a read issued at edge k, `dOe` goes high and `dOut` carries the word after edge k+2.
- R2: For a write issued at edge k, the word on `dIn` at edge k+2 is stored. A read issued at the edge after a write to the same address returns the new word, and reads and writes may alternate on consecutive cycles.
- R3: While `clkEnN` is sampled high, every input is ignored and every register holds its value, outputs included. Once `clkEnN` is low again, the pipeline resumes where it stopped.
- R4: `startN` low loads a new operation: `writeN` low selects a write, high a read. `startN` high continues the current burst with the same direction. In linear order the two low address bits step by +1 modulo 4, so start 1 gives 1,2,3,0 and the burst wraps to the first word after the fourth.
- R5: With `burstIlv` high, beat n of a burst uses low bits equal to (start XOR n). Start 1 gives 1,0,3,2.
- R6: The device is selected only when `csN`=0, `csHi`=1 and `csLoN`=0. When `startN` is low and any select is inactive, no operation starts and any running burst ends. Operations already in the pipeline still complete.
- R7: `dOe` is low after edge k+2 when the operation at edge k was a write or a deselect.
- R8: `laneWrN[i]` low, sampled with the operation's own control cycle, enables storage of bits [9i+8:9i]. Lanes whose bit is high keep their old contents, and each burst beat uses its own mask.
- R9: `outEnN` high forces `dOe` low at once, with no clock edge needed, and does not disturb the pipeline.
- R10: A burst continue while no burst is active is a no-operation.
- R11: After reset `dOe` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the control pipeline |
| clkEnN | input | 1 | Active-low clock enable; high stalls the block |
| addr | input | ADDR_W | Word address, taken when a new operation loads |
| startN | input | 1 | Low loads a new operation, high continues the burst |
| writeN | input | 1 | Low selects write, high selects read |
| csN | input | 1 | Active-low chip select |
| csHi | input | 1 | Active-high chip select |
| csLoN | input | 1 | Second active-low chip select |
| laneWrN | input | LANES | Active-low per-lane write enables |
| burstIlv | input | 1 | Burst order: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous active-low output enable |
| dIn | input | LANES*LANE_W | Write data (input side of the bus) |
| dOut | output | LANES*LANE_W | Read data (output side of the bus) |
| dOe | output | 1 | Drive enable for the data bus |

## Verification
The hardest case to reach is a stall that arrives while reads are still in flight. The bench queues two reads and a deselect. It then holds the clock enable high for several cycles and drives a write to one of the addresses being read, with new data on the bus. It checks that the first read's word stays on the outputs through the stall and that the second read's word comes out one cycle after release. It then reads the address back to confirm that the write offered during the stall never took effect. Bursts are checked with wrap-around in both orders, and with a mid-burst deselect that ends the sequence while the earlier beat still completes.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes passed from control to datapath for the stage whose data moves now
  typedef struct packed {
    logic doRead;
    logic doWrite;
  } strobe_t;

  // low two address bits of burst beat n
  function automatic logic [1:0] beatLow(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       ilv);
    return ilv ? (start ^ beat) : 2'(start + beat);
  endfunction

endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              startN,
  input  logic              writeN,
  input  logic              csN,
  input  logic              csHi,
  input  logic              csLoN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstIlv,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [LANES-1:0]  opLanes
);

  localparam int HI_W = ADDR_W - 2;

  logic              selOk;
  logic              burstOn;
  logic              burstWr;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beatCnt;
  logic [1:0]        nextBeat;

  op_e               newOp;
  logic [ADDR_W-1:0] newAddr;

  // stage A: captured at the operation's edge; stage B: one edge later
  op_e               aOp, bOp;
  logic [ADDR_W-1:0] aAddr, bAddr;
  logic [LANES-1:0]  aLanes, bLanes;

  assign selOk    = !csN && csHi && !csLoN;
  assign nextBeat = 2'(beatCnt + 2'd1);

  always_comb begin
    newOp   = OP_NONE;
    newAddr = aAddr;
    if (!startN) begin
      newAddr = addr;
      if (selOk) newOp = writeN ? OP_READ : OP_WRITE;
    end else if (burstOn) begin
      newOp   = burstWr ? OP_WRITE : OP_READ;
      newAddr = {baseAddr[ADDR_W-1:2], beatLow(baseAddr[1:0], nextBeat, burstIlv)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn  <= 1'b0;
      burstWr  <= 1'b0;
      baseAddr <= '0;
      beatCnt  <= 2'd0;
      aOp      <= OP_NONE;
      aAddr    <= '0;
      aLanes   <= '0;
      bOp      <= OP_NONE;
      bAddr    <= '0;
      bLanes   <= '0;
    end else if (!clkEnN) begin
      if (!startN) begin
        burstOn  <= selOk;
        burstWr  <= !writeN;
        baseAddr <= addr;
        beatCnt  <= 2'd0;
      end else if (burstOn) begin
        beatCnt  <= nextBeat;
      end
      aOp    <= newOp;
      aAddr  <= newAddr;
      aLanes <= ~laneWrN;
      bOp    <= aOp;
      bAddr  <= aAddr;
      bLanes <= aLanes;
    end
  end

  assign strb.doRead  = (bOp == OP_READ);
  assign strb.doWrite = (bOp == OP_WRITE);
  assign opAddr       = bAddr;
  assign opLanes      = bLanes;

  logic unusedHi;
  assign unusedHi = (HI_W < 0);

  AST_DESEL_NOOP: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !startN && !selOk) |=> (aOp == OP_NONE)); // R6

  AST_IDLE_CONT: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && startN && !burstOn) |=> (aOp == OP_NONE)); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(aOp) && $stable(bOp) && $stable(beatCnt) && $stable(burstOn))); // R3

endmodule

// File: rtl/zbt_datapath.sv
`timescale 1ns/1ps
module zbt_datapath
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    outEnN,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES-1:0]        opLanes,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic              driveReg;
  logic [DATA_W-1:0] rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        driveReg <= 1'b0;
    else if (!clkEnN) driveReg <= strb.doRead;
  end

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] rdLane;

    always_ff @(posedge clk) begin
      if (!clkEnN) begin
        if (strb.doWrite && opLanes[l]) laneMem[opAddr] <= dIn[l*LANE_W +: LANE_W];
        if (strb.doRead)                rdLane          <= laneMem[opAddr];
      end
    end

    assign rdData[l*LANE_W +: LANE_W] = rdLane;
  end

  assign dOut = rdData;
  assign dOe  = driveReg && !outEnN;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doRead && strb.doWrite)); // R2

  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && strb.doWrite) |=> !dOe); // R7

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    startN,
  input  logic                    writeN,
  input  logic                    csN,
  input  logic                    csHi,
  input  logic                    csLoN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    burstIlv,
  input  logic                    outEnN,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOe
);

  strobe_t           strb;
  logic [ADDR_W-1:0] opAddr;
  logic [LANES-1:0]  opLanes;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .addr(addr),
    .startN(startN), .writeN(writeN), .csN(csN), .csHi(csHi), .csLoN(csLoN),
    .laneWrN(laneWrN), .burstIlv(burstIlv),
    .strb(strb), .opAddr(opAddr), .opLanes(opLanes)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .outEnN(outEnN),
    .strb(strb), .opAddr(opAddr), .opLanes(opLanes),
    .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

endmodule

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;

  logic        clk = 1'b0;
  logic        rstN, clkEnN, startN, writeN, csN, csHi, csLoN, burstIlv, outEnN;
  logic [7:0]  addr;
  logic [1:0]  laneWrN;
  logic [17:0] dIn, dOut;
  logic        dOe;
  int          total = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  zbt_sram dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .addr(addr), .startN(startN),
    .writeN(writeN), .csN(csN), .csHi(csHi), .csLoN(csLoN), .laneWrN(laneWrN),
    .burstIlv(burstIlv), .outEnN(outEnN), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  // {ld, wr, sel, lanes[1:0], addr[7:0], din[17:0], expOe, expD[17:0]}
  // ld=1 loads, ld=0 continues; row i's expectation is for the op of row i-2
  localparam logic [49:0] VEC [24] = '{
    {1'b1,1'b1,1'b1,2'b11,8'h10,18'h00000,1'b0,18'h00000},
    {1'b1,1'b1,1'b1,2'b11,8'h11,18'h00000,1'b0,18'h00000},
    {1'b1,1'b0,1'b1,2'b00,8'h10,18'h12345,1'b0,18'h00000},
    {1'b1,1'b0,1'b1,2'b00,8'h11,18'h0ABCD,1'b0,18'h00000},
    {1'b1,1'b0,1'b0,2'b00,8'h00,18'h00000,1'b1,18'h12345},
    {1'b1,1'b1,1'b1,2'b11,8'h12,18'h00000,1'b1,18'h0ABCD},
    {1'b1,1'b0,1'b1,2'b00,8'h12,18'h00000,1'b0,18'h00000},
    {1'b1,1'b1,1'b1,2'b10,8'h12,18'h2A5A5,1'b0,18'h00000},
    {1'b1,1'b0,1'b0,2'b00,8'h00,18'h00000,1'b1,18'h2A5A5},
    {1'b1,1'b0,1'b1,2'b00,8'h12,18'h155AA,1'b0,18'h00000},
    {1'b1,1'b0,1'b0,2'b00,8'h00,18'h00000,1'b0,18'h00000},
    {1'b1,1'b0,1'b0,2'b00,8'h00,18'h00000,1'b1,18'h155A5},
    {1'b1,1'b1,1'b1,2'b11,8'h21,18'h00000,1'b0,18'h00000},
    {1'b0,1'b0,1'b1,2'b11,8'h00,18'h00000,1'b0,18'h00000},
    {1'b0,1'b0,1'b1,2'b11,8'h00,18'h11111,1'b0,18'h00000},
    {1'b0,1'b0,1'b1,2'b11,8'h00,18'h22222,1'b0,18'h00000},
    {1'b1,1'b0,1'b1,2'b00,8'h22,18'h33333,1'b0,18'h00000},
    {1'b0,1'b0,1'b1,2'b00,8'h00,18'h04444,1'b0,18'h00000},
    {1'b0,1'b0,1'b1,2'b00,8'h00,18'h00000,1'b1,18'h22222},
    {1'b0,1'b0,1'b1,2'b00,8'h00,18'h00000,1'b1,18'h33333},
    {1'b1,1'b0,1'b0,2'b00,8'h00,18'h00000,1'b1,18'h04444},
    {1'b0,1'b0,1'b1,2'b00,8'h00,18'h00000,1'b1,18'h11111},
    {1'b1,1'b0,1'b0,2'b00,8'h00,18'h00000,1'b0,18'h00000},
    {1'b1,1'b0,1'b0,2'b00,8'h00,18'h00000,1'b0,18'h00000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // drive one cycle between edges, then sample 1 ns after the rising edge
  task automatic step(input logic sN, input logic wN, input logic c1, input logic c2,
                      input logic c3, input logic [1:0] bw, input logic [7:0] a,
                      input logic [17:0] d);
    @(negedge clk);
    startN = sN; writeN = wN; csN = c1; csHi = c2; csLoN = c3;
    laneWrN = bw; addr = a; dIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, a, 18'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [17:0] d);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, a, d);
  endtask

  task automatic idle(input logic [17:0] d);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 8'h00, d);
  endtask

  task automatic cont(input logic [17:0] d);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'h00, d);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; startN = 1'b1; writeN = 1'b1;
    csN = 1'b1; csHi = 1'b0; csLoN = 1'b1; laneWrN = 2'b11;
    burstIlv = 1'b0; outEnN = 1'b0; addr = '0; dIn = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset dOe", {31'b0, dOe}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    idle(18'h0);
    idle(18'h0);
    chk("R11 idle after reset dOe", {31'b0, dOe}, 32'd0);

    // table walk: R1 R2 R4 R7 R8 R10
    for (int i = 0; i < 24; i++) begin
      automatic logic [49:0] v = VEC[i];
      step(~v[49], ~v[48], ~v[47] ? 1'b0 : 1'b0, v[47], 1'b0, ~v[46:45], v[44:37], v[36:19]);
      chk($sformatf("R1/R2/R4/R7/R8/R10 row %0d dOe", i), {31'b0, dOe}, {31'b0, v[18]});
      if (v[18]) chk($sformatf("R1/R2/R4/R8 row %0d dOut", i), {14'b0, dOut}, {14'b0, v[17:0]});
    end

    // R3: stall with reads in flight; a write offered during the stall is ignored
    rd(8'h10);
    rd(8'h12);
    idle(18'h0);
    chk("R1 read before stall dOe", {31'b0, dOe}, 32'd1);
    chk("R1 read before stall dOut", {14'b0, dOut}, {14'b0, 18'h12345});
    for (int s = 0; s < 3; s++) begin
      clkEnN = 1'b1;
      wr(8'h10, 18'h3FFFF);
      chk("R3 stall holds dOe", {31'b0, dOe}, 32'd1);
      chk("R3 stall holds dOut", {14'b0, dOut}, {14'b0, 18'h12345});
    end
    clkEnN = 1'b0;
    idle(18'h3FFFF);
    chk("R3 resumed second read", {14'b0, dOut}, {14'b0, 18'h155A5});
    idle(18'h0);
    chk("R7 dOe low after deselect", {31'b0, dOe}, 32'd0);
    rd(8'h10); idle(18'h0); idle(18'h0);
    chk("R3 stalled write ignored", {14'b0, dOut}, {14'b0, 18'h12345});

    // R9: asynchronous output enable
    rd(8'h11); idle(18'h0); idle(18'h0);
    chk("R9 dOe before outEnN", {31'b0, dOe}, 32'd1);
    outEnN = 1'b1; #0.5;
    chk("R9 outEnN forces dOe low", {31'b0, dOe}, 32'd0);
    outEnN = 1'b0; #0.5;
    chk("R9 dOe restored", {31'b0, dOe}, 32'd1);
    chk("R9 data kept", {14'b0, dOut}, {14'b0, 18'h0ABCD});

    // R6: each chip select alone blocks a write
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h10, 18'h0);
    idle(18'h0); idle(18'h3FFFF);
    chk("R6 csN inactive no op", {31'b0, dOe}, 32'd0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h10, 18'h0);
    idle(18'h0); idle(18'h3FFFF);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 8'h10, 18'h0);
    idle(18'h0); idle(18'h3FFFF);
    rd(8'h10); idle(18'h0); idle(18'h0);
    chk("R6 deselected writes not stored", {14'b0, dOut}, {14'b0, 18'h12345});

    // R6: deselect stops a burst, earlier beat still completes
    rd(8'h21);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, 18'h0);
    cont(18'h0);
    chk("R6 pending beat completes", {14'b0, dOut}, {14'b0, 18'h11111});
    cont(18'h0);
    chk("R6 deselect gives no data", {31'b0, dOe}, 32'd0);
    idle(18'h0);
    chk("R6 burst stopped", {31'b0, dOe}, 32'd0);

    // R5: interleaved burst from low bits 01 -> 1,0,3,2
    burstIlv = 1'b1;
    wr(8'h40, 18'h0);
    wr(8'h41, 18'h0);
    wr(8'h42, 18'h00A40);
    wr(8'h43, 18'h00A41);
    idle(18'h00A42);
    idle(18'h00A43);
    rd(8'h41);
    cont(18'h0);
    cont(18'h0);
    chk("R5 beat0", {14'b0, dOut}, {14'b0, 18'h00A41});
    cont(18'h0);
    chk("R5 beat1", {14'b0, dOut}, {14'b0, 18'h00A40});
    idle(18'h0);
    chk("R5 beat2", {14'b0, dOut}, {14'b0, 18'h00A43});
    idle(18'h0);
    chk("R5 beat3", {14'b0, dOut}, {14'b0, 18'h00A42});
    idle(18'h0);
    chk("R5 end of burst dOe", {31'b0, dOe}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule